// File: doc/BRIEF.md
# Pulse Accumulator With Flag Register

This block is a 16-bit pulse accumulator for a microcontroller timer. It watches one external input pin, which it first passes through a two-flop synchronizer. It then counts in one of two ways. In event mode it adds one for each selected edge on the pin. In gated mode it adds one for each pulse of a clock-enable input while the pin holds its active level. The clock-enable input stands for the divided timer clock.

Two sticky flags record a counter wrap and an input event. Each flag drives its own interrupt request, and each request can be masked. A byte-wide register bus gives access to four registers. A control byte at address 0 holds the run, mode, polarity, interrupt-enable and fast-clear bits. The counter's high and low bytes sit at addresses 1 and 2. The flag byte sits at address 3.

A small state machine follows the counting mode. Its states are `ST_IDLE` (stopped), `ST_EVENT` (counting edges), `ST_GATE_SHUT` (gated mode, gate inactive) and `ST_GATE_OPEN` (gated mode, gate active).

Its transitions are:
- Any state goes to `ST_IDLE` when the run bit is clear.
- `ST_IDLE` goes to `ST_EVENT`, `ST_GATE_SHUT` or `ST_GATE_OPEN`, depending on the mode bit and the gate level.
- `ST_EVENT` and the two gated states move between each other when the mode bit changes.
- `ST_GATE_SHUT` goes to `ST_GATE_OPEN` when the gate becomes active.
- `ST_GATE_OPEN` goes to `ST_GATE_SHUT` when the gate falls inactive. This transition is the trailing edge of the gate, and it raises the input event.

Top module: `pacc_top`

## Requirements
- R1: After reset, all four registers read 0x00, and both interrupt outputs are low.
- R2: In event mode (control bit1 = 0), the input passes through two synchronizer flops. The counter adds one for each edge selected by control bit2: 0 selects rising edges and 1 selects falling edges. The other edge does not change the count. The new count is visible once three rising clock edges have passed since the pin changed.
- R3: In gated mode (control bit1 = 1), the counter adds one in each cycle where `tick_en_i` is high and the synchronized pin is at its active level. Control bit2 sets that level: 0 means active high and 1 means active low. In every other cycle the count does not change, and the count never steps by more than one.
- R4: In event mode, every counted edge sets the input flag (flag byte bit0).
- R5: In gated mode, the input flag sets when the gate leaves its active level. It does not set when the gate enters its active level.
- R6: When the counter wraps from 0xFFFF to 0x0000, the overflow flag (flag byte bit1) sets.
- R7: `irq_ovf_o` is the overflow flag masked by control bit3. `irq_in_o` is the input flag masked by control bit4.
- R8: Writing 1 to a flag bit clears that flag. Writing 0 leaves it unchanged. Flag byte bits 7..2 read as zero and ignore writes.
- R9: If a flag set and a write-1 clear of the same flag happen in the same cycle, the flag ends up set.
- R10: When control bit5 is set, any read or write at address 1 or 2 clears both flags. When bit5 is clear, such accesses leave the flags alone.
- R11: When control bit0 (run) is clear, the counter does not count and no flag is set. Register reads and writes still work.
- R12: The control byte reads back bits 5..0, with bits 7..6 reading as zero. A write to address 1 loads the counter's high byte, and a write to address 2 loads its low byte. A counter byte write overrides any increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pa_pin_i | input | 1 | External accumulator input (asynchronous) |
| tick_en_i | input | 1 | Divided timer clock enable, used in gated mode |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data (combinational, 0 when not selected) |
| irq_ovf_o | output | 1 | Overflow interrupt request |
| irq_in_o | output | 1 | Input event interrupt request |

## Verification
The assertions check the following rules on every cycle:
- Without a byte write, the count steps by zero or one.
- A wrap always leaves the overflow flag set.
- A stopped block neither counts nor raises a flag.
- A set event always beats a clear in the same cycle.
- Interrupt requests rise only with their enables set.
- The padding bits of the flag byte read as zero.

Some behaviour needs the bench's scenarios, because only a sequence of stimulus can show it. These scenarios cover:
- edge polarity selection;
- the gated-mode difference between the leading and trailing gate edges;
- the synchronizer latency;
- the write-1-to-clear semantics;
- the fast-clear side effect of counter accesses;
- the ordering of a byte write against a coincident tick.

// File: rtl/pacc_pkg.sv
`timescale 1ns/1ps
package pacc_pkg;

    localparam int CNT_W   = 16;
    localparam int BYTE_W  = 8;
    localparam int LANES   = CNT_W / BYTE_W;
    localparam int NFLAG   = 2;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_CNT_HI = 2'd1;
    localparam logic [1:0] ADDR_CNT_LO = 2'd2;
    localparam logic [1:0] ADDR_FLAG   = 2'd3;

    // flag positions inside the flag byte
    localparam int FLG_IN  = 0;
    localparam int FLG_OVF = 1;

    // control byte, bit5 down to bit0
    typedef struct packed {
        logic fclr;     // bit5: counter access clears flags
        logic in_ie;    // bit4: input interrupt enable
        logic ovf_ie;   // bit3: overflow interrupt enable
        logic act_low;  // bit2: falling edge / active-low gate
        logic gated;    // bit1: gated accumulation mode
        logic run;      // bit0: global enable
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_EVENT     = 2'd1,
        ST_GATE_SHUT = 2'd2,
        ST_GATE_OPEN = 2'd3
    } acc_state_t;

endpackage

// File: rtl/pacc_insync.sv
`timescale 1ns/1ps
module pacc_insync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= pin_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign lvl_o  = chain_q[STAGES-1];
    assign rise_o =  chain_q[STAGES-1] & ~prev_q;
    assign fall_o = ~chain_q[STAGES-1] &  prev_q;

endmodule

// File: rtl/pacc_mode_fsm.sv
`timescale 1ns/1ps
module pacc_mode_fsm
    import pacc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic gated_i,
    input  logic act_low_i,
    input  logic lvl_i,
    input  logic rise_i,
    input  logic fall_i,
    input  logic tick_i,
    output logic inc_o,
    output logic in_evt_o
);

    acc_state_t st_q, st_d;
    logic       gate_act;
    logic       act_edge;

    assign gate_act = lvl_i ^ act_low_i;
    assign act_edge = act_low_i ? fall_i : rise_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        if (!run_i) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (gated_i) st_d = gate_act ? ST_GATE_OPEN : ST_GATE_SHUT;
                    else         st_d = ST_EVENT;
                end
                ST_EVENT: begin
                    if (gated_i) st_d = gate_act ? ST_GATE_OPEN : ST_GATE_SHUT;
                end
                ST_GATE_SHUT: begin
                    if (!gated_i)     st_d = ST_EVENT;
                    else if (gate_act) st_d = ST_GATE_OPEN;
                end
                ST_GATE_OPEN: begin
                    if (!gated_i)      st_d = ST_EVENT;
                    else if (!gate_act) st_d = ST_GATE_SHUT;
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        inc_o    = 1'b0;
        in_evt_o = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                inc_o    = 1'b0;
                in_evt_o = 1'b0;
            end
            ST_EVENT: begin
                inc_o    = run_i & act_edge;
                in_evt_o = run_i & act_edge;
            end
            ST_GATE_SHUT: begin
                inc_o    = run_i & tick_i & gate_act;
            end
            ST_GATE_OPEN: begin
                inc_o    = run_i & tick_i & gate_act;
                in_evt_o = run_i & ~gate_act;   // trailing gate edge
            end
            default: begin
                inc_o    = 1'b0;
                in_evt_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pacc_counter.sv
`timescale 1ns/1ps
module pacc_counter #(
    parameter int CW = 16,
    parameter int BW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inc_i,
    input  logic [CW/BW-1:0]   lane_we_i,
    input  logic [BW-1:0]      lane_wdata_i,
    output logic [CW-1:0]      count_o,
    output logic               wrap_o
);

    localparam int NL = CW / BW;

    logic [CW-1:0] cnt_q, cnt_d;
    logic          any_we;

    assign any_we = |lane_we_i;

    always_comb begin
        cnt_d = cnt_q;
        if (any_we) begin
            for (int i = 0; i < NL; i++) begin
                if (lane_we_i[i]) cnt_d[i*BW +: BW] = lane_wdata_i;
            end
        end else if (inc_i) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign wrap_o  = inc_i & ~any_we & (&cnt_q);
    assign count_o = cnt_q;

endmodule

// File: rtl/pacc_flags.sv
`timescale 1ns/1ps
module pacc_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] w1c_i,
    input  logic         fclr_i,
    output logic [N-1:0] flag_o
);

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                    flag_o[g] <= 1'b0;
                else if (set_i[g])             flag_o[g] <= 1'b1;
                else if (w1c_i[g] || fclr_i)   flag_o[g] <= 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/pacc_top.sv
`timescale 1ns/1ps
module pacc_top
    import pacc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pa_pin_i,
    input  logic       tick_en_i,
    input  logic       bus_sel_i,
    input  logic       bus_wr_i,
    input  logic [1:0] bus_addr_i,
    input  logic [7:0] bus_wdata_i,
    output logic [7:0] bus_rdata_o,
    output logic       irq_ovf_o,
    output logic       irq_in_o
);

    ctrl_t            ctrl_q;
    logic             lvl, rise, fall;
    logic             inc, in_set, wrap;
    logic [LANES-1:0] lane_we;
    logic             any_we;
    logic [CNT_W-1:0] count;
    logic [NFLAG-1:0] flags, flag_set, flag_w1c;
    logic             cnt_access, fast_clr;
    logic             run, ovf_ie, in_ie;

    assign run    = ctrl_q.run;
    assign ovf_ie = ctrl_q.ovf_ie;
    assign in_ie  = ctrl_q.in_ie;

    // control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (bus_sel_i && bus_wr_i && bus_addr_i == ADDR_CTRL) begin
            ctrl_q <= ctrl_t'(bus_wdata_i[CTRL_W-1:0]);
        end
    end

    // counter byte lanes: lane LANES-1 is the high byte
    always_comb begin
        lane_we = '0;
        if (bus_sel_i && bus_wr_i) begin
            if (bus_addr_i == ADDR_CNT_HI) lane_we[LANES-1] = 1'b1;
            if (bus_addr_i == ADDR_CNT_LO) lane_we[0]       = 1'b1;
        end
    end
    assign any_we = |lane_we;

    assign cnt_access = bus_sel_i &&
                        (bus_addr_i == ADDR_CNT_HI || bus_addr_i == ADDR_CNT_LO);
    assign fast_clr   = ctrl_q.fclr & cnt_access;

    always_comb begin
        flag_w1c = '0;
        if (bus_sel_i && bus_wr_i && bus_addr_i == ADDR_FLAG)
            flag_w1c = bus_wdata_i[NFLAG-1:0];
    end

    always_comb begin
        flag_set          = '0;
        flag_set[FLG_OVF] = wrap;
        flag_set[FLG_IN]  = in_set;
    end

    pacc_insync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pa_pin_i),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    pacc_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (ctrl_q.run),
        .gated_i   (ctrl_q.gated),
        .act_low_i (ctrl_q.act_low),
        .lvl_i     (lvl),
        .rise_i    (rise),
        .fall_i    (fall),
        .tick_i    (tick_en_i),
        .inc_o     (inc),
        .in_evt_o  (in_set)
    );

    pacc_counter #(.CW(CNT_W), .BW(BYTE_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .inc_i        (inc),
        .lane_we_i    (lane_we),
        .lane_wdata_i (bus_wdata_i),
        .count_o      (count),
        .wrap_o       (wrap)
    );

    pacc_flags #(.N(NFLAG)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (flag_set),
        .w1c_i  (flag_w1c),
        .fclr_i (fast_clr),
        .flag_o (flags)
    );

    // read mux
    always_comb begin
        bus_rdata_o = '0;
        if (bus_sel_i) begin
            unique case (bus_addr_i)
                ADDR_CTRL:   bus_rdata_o = {{(BYTE_W-CTRL_W){1'b0}}, ctrl_q};
                ADDR_CNT_HI: bus_rdata_o = count[CNT_W-1 -: BYTE_W];
                ADDR_CNT_LO: bus_rdata_o = count[BYTE_W-1:0];
                ADDR_FLAG:   bus_rdata_o = {{(BYTE_W-NFLAG){1'b0}}, flags};
                default:     bus_rdata_o = '0;
            endcase
        end
    end

    assign irq_ovf_o = flags[FLG_OVF] & ctrl_q.ovf_ie;
    assign irq_in_o  = flags[FLG_IN]  & ctrl_q.in_ie;

endmodule

// File: rtl/pacc_chk.sv
`timescale 1ns/1ps
module pacc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        run,
    input logic        inc,
    input logic        any_we,
    input logic        in_set,
    input logic [15:0] count,
    input logic [1:0]  flags,
    input logic        ovf_ie,
    input logic        in_ie,
    input logic        irq_ovf,
    input logic        irq_in,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [1:0]  bus_addr,
    input logic [7:0]  bus_rdata
);

    AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !any_we && count == 16'hFFFF) |=> (count == 16'h0000 && flags[1])); // R6

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !any_we |=> (count == $past(count) || count == $past(count) + 16'd1)); // R3

    AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !any_we) |=> $stable(count)); // R11

    AST_RUN_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!$rose(flags[0]) && !$rose(flags[1]))); // R11

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        in_set |=> flags[0]); // R9

    AST_IRQ_OVF_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_ovf) |-> ovf_ie); // R7

    AST_IRQ_IN_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        irq_in |-> (flags[0] && in_ie)); // R7

    AST_FLAG_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == 2'd3) |-> bus_rdata[7:2] == 6'd0); // R8

endmodule

bind pacc_top pacc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .inc       (inc),
    .any_we    (any_we),
    .in_set    (in_set),
    .count     (count),
    .flags     (flags),
    .ovf_ie    (ovf_ie),
    .in_ie     (in_ie),
    .irq_ovf   (irq_ovf_o),
    .irq_in    (irq_in_o),
    .bus_sel   (bus_sel_i),
    .bus_wr    (bus_wr_i),
    .bus_addr  (bus_addr_i),
    .bus_rdata (bus_rdata_o)
);

// File: tb/pacc_top_tb_top.sv
`timescale 1ns/1ps
module pacc_top_tb_top;

    localparam real CLK_PERIOD = 5.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin = 1'b0;
    logic       tick = 1'b0;
    logic       sel = 1'b0;
    logic       wr = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq_ovf, irq_in;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int         kind;   // 0 read data, 1 irq_ovf, 2 irq_in
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t sb_q[$];
    event  sample_ev;

    always #(CLK_PERIOD/2.0) clk = ~clk;

    pacc_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pa_pin_i   (pin),
        .tick_en_i  (tick),
        .bus_sel_i  (sel),
        .bus_wr_i   (wr),
        .bus_addr_i (addr),
        .bus_wdata_i(wdata),
        .bus_rdata_o(rdata),
        .irq_ovf_o  (irq_ovf),
        .irq_in_o   (irq_in)
    );

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(sample_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb_q.pop_front();
                if (it.kind == 0)      act = rdata;
                else if (it.kind == 1) act = {7'd0, irq_ovf};
                else                   act = {7'd0, irq_in};
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: kind %0d actual 0x%02h expected 0x%02h",
                             it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic rd_expect(input logic [1:0] a, input logic [7:0] e, input string req);
        item_t it;
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1;
        it.kind = 0; it.exp = e; it.req = req;
        sb_q.push_back(it);
        -> sample_ev;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic irq_expect(input int k, input logic e, input string req);
        item_t it;
        @(negedge clk);
        #1;
        it.kind = k; it.exp = {7'd0, e}; it.req = req;
        sb_q.push_back(it);
        -> sample_ev;
    endtask

    task automatic set_pin(input logic v);
        @(negedge clk);
        pin = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_expect(2'd0, 8'h00, "R1 ctrl");
        rd_expect(2'd1, 8'h00, "R1 cnt hi");
        rd_expect(2'd2, 8'h00, "R1 cnt lo");
        rd_expect(2'd3, 8'h00, "R1 flags");
        irq_expect(1, 1'b0, "R1 irq_ovf");
        irq_expect(2, 1'b0, "R1 irq_in");

        // R12 register map and readback
        bus_write(2'd0, 8'hFF);
        rd_expect(2'd0, 8'h3F, "R12 ctrl readback");
        bus_write(2'd0, 8'h00);
        bus_write(2'd1, 8'h12);
        bus_write(2'd2, 8'h34);
        rd_expect(2'd1, 8'h12, "R12 hi byte");
        rd_expect(2'd2, 8'h34, "R12 lo byte");
        bus_write(2'd1, 8'h00);
        bus_write(2'd2, 8'h00);

        // R2/R4 event mode, rising edges
        bus_write(2'd0, 8'h01);
        for (int i = 0; i < 3; i++) begin
            set_pin(1'b1);
            set_pin(1'b0);
        end
        rd_expect(2'd2, 8'h03, "R2 rising count");
        rd_expect(2'd3, 8'h01, "R4 event flag");
        irq_expect(2, 1'b0, "R7 irq_in masked");
        bus_write(2'd0, 8'h11);
        irq_expect(2, 1'b1, "R7 irq_in enabled");

        // R8 write-1-to-clear
        bus_write(2'd3, 8'h00);
        rd_expect(2'd3, 8'h01, "R8 write 0 keeps");
        bus_write(2'd3, 8'hFC);
        rd_expect(2'd3, 8'h01, "R8 upper bits ignored");
        bus_write(2'd3, 8'h01);
        rd_expect(2'd3, 8'h00, "R8 write 1 clears");
        irq_expect(2, 1'b0, "R7 irq_in after clear");

        // R2 falling edge selected
        bus_write(2'd0, 8'h05);
        set_pin(1'b1);
        rd_expect(2'd2, 8'h03, "R2 rising ignored");
        set_pin(1'b0);
        rd_expect(2'd2, 8'h04, "R2 falling count");
        rd_expect(2'd3, 8'h01, "R4 falling flag");
        bus_write(2'd3, 8'h01);

        // R3/R5 gated mode, active high
        bus_write(2'd0, 8'h03);
        ticks(3);
        rd_expect(2'd2, 8'h04, "R3 gate closed");
        set_pin(1'b1);
        rd_expect(2'd3, 8'h00, "R5 leading edge no flag");
        ticks(5);
        rd_expect(2'd2, 8'h09, "R3 gate open ticks");
        set_pin(1'b0);
        rd_expect(2'd3, 8'h01, "R5 trailing edge flag");
        ticks(2);
        rd_expect(2'd2, 8'h09, "R3 closed again");
        bus_write(2'd3, 8'h01);

        // R3/R5 gated mode, active low
        bus_write(2'd0, 8'h07);
        ticks(2);
        rd_expect(2'd2, 8'h0B, "R3 active low ticks");
        rd_expect(2'd3, 8'h00, "R5 no flag while open");
        set_pin(1'b1);
        rd_expect(2'd3, 8'h01, "R5 active low trailing");
        bus_write(2'd3, 8'h01);

        // R6/R7 overflow
        bus_write(2'd0, 8'h01);
        bus_write(2'd1, 8'hFF);
        bus_write(2'd2, 8'hFF);
        set_pin(1'b0);
        set_pin(1'b1);
        rd_expect(2'd1, 8'h00, "R6 wrap hi");
        rd_expect(2'd2, 8'h00, "R6 wrap lo");
        rd_expect(2'd3, 8'h03, "R6 overflow flag");
        irq_expect(1, 1'b0, "R7 irq_ovf masked");
        bus_write(2'd0, 8'h09);
        irq_expect(1, 1'b1, "R7 irq_ovf enabled");
        bus_write(2'd3, 8'h02);
        rd_expect(2'd3, 8'h01, "R8 clear ovf only");
        irq_expect(1, 1'b0, "R7 irq_ovf cleared");
        bus_write(2'd3, 8'h01);

        // R9 set beats simultaneous clear
        bus_write(2'd0, 8'h01);
        set_pin(1'b0);
        @(negedge clk); pin = 1'b1;
        @(negedge clk);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = 2'd3; wdata = 8'h01;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
        rd_expect(2'd3, 8'h01, "R9 set wins");
        rd_expect(2'd2, 8'h01, "R9 count moved");
        bus_write(2'd3, 8'h03);

        // R10 fast clear
        set_pin(1'b0);
        set_pin(1'b1);
        rd_expect(2'd2, 8'h02, "R10 read without fclr");
        rd_expect(2'd3, 8'h01, "R10 flag kept");
        bus_write(2'd0, 8'h21);
        rd_expect(2'd1, 8'h00, "R10 read hi");
        rd_expect(2'd3, 8'h00, "R10 read clears");
        set_pin(1'b0);
        set_pin(1'b1);
        bus_write(2'd2, 8'h20);
        rd_expect(2'd3, 8'h00, "R10 write clears");
        rd_expect(2'd2, 8'h20, "R10 written value");

        // R11 stopped
        bus_write(2'd0, 8'h00);
        bus_write(2'd2, 8'h42);
        set_pin(1'b0);
        set_pin(1'b1);
        rd_expect(2'd2, 8'h42, "R11 no event count");
        rd_expect(2'd3, 8'h00, "R11 no flag");
        bus_write(2'd0, 8'h02);
        ticks(3);
        rd_expect(2'd2, 8'h42, "R11 no gated count");

        // R12 byte write beats coincident increment
        bus_write(2'd0, 8'h03);
        bus_write(2'd1, 8'h01);
        bus_write(2'd2, 8'h00);
        @(negedge clk);
        tick = 1'b1; sel = 1'b1; wr = 1'b1; addr = 2'd2; wdata = 8'h55;
        @(negedge clk);
        tick = 1'b0; sel = 1'b0; wr = 1'b0;
        rd_expect(2'd2, 8'h55, "R12 write over tick");
        rd_expect(2'd1, 8'h01, "R12 hi kept");
        ticks(1);
        rd_expect(2'd2, 8'h56, "R3 tick after write");

        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule